// File: doc/BRIEF.md
# Fault Class Tally and Coverage Unit

This block tallies fault status reports and turns the tallies into three coverage figures. Each accepted input beat names the status class of one fault as a 4-bit code. The block keeps a saturating counter per class, sums the classes into five categories, and exposes those category totals continuously.

On request it captures the current totals and computes three ratios as unsigned fixed-point percentages scaled by 10000, so 10000 means 100.00 %. The ratios are test coverage, fault coverage and ATPG effectiveness. Three restoring dividers run side by side, each producing one quotient bit per clock. A one-cycle done strobe marks the moment the results become valid. A zero denominator gives a result of 0 and raises a per-ratio flag.

Top module: `fault_tally_cov`

## Requirements
- R1: After a synchronous active-low reset, all category totals, ratios, div_zero flags, err_code, busy and done read 0.
- R2: A valid beat increments the counter of the class it names. Codes 0, 1 and 2 fall in category 0 (detected). Codes 3 and 4 fall in category 1 (possibly detected). Codes 5 to 8 fall in category 2 (undetectable). Code 9 falls in category 3 (ATPG untestable). Codes 10 and 11 fall in category 4 (not detected). Category k is reported in cat_total bits [k*SUM_W +: SUM_W], where SUM_W = CNT_W+4.
- R3: A valid beat with code 12 to 15 changes no count, and err_code is high in the cycle after that beat and low after any other cycle.
- R4: Each class counter stops at 2^CNT_W-1 and does not wrap.
- R5: clr zeroes every counter on the next edge and takes priority over a beat in the same cycle.
- R6: test_cov = floor(detected*10000 / (all - undetectable)).
- R7: fault_cov = floor(detected*10000 / all).
- R8: atpg_eff = floor((detected + possibly detected + undetectable)*10000 / all).
- R9: A ratio whose denominator is zero reads 0, and its div_zero bit is set (bit 0 test_cov, bit 1 fault_cov, bit 2 atpg_eff).
- R10: calc_start accepted while idle raises busy on the next edge. done pulses for exactly one cycle, NUM_W = SUM_W+14 edges after the accepting edge. The results use the totals present at acceptance and hold until the next accepted start. calc_start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of all class counters |
| in_valid | input | 1 | Beat strobe for in_code |
| in_code | input | 4 | Fault class code |
| err_code | output | 1 | Out-of-range code seen on previous cycle |
| calc_start | input | 1 | Request a coverage computation |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle result strobe |
| test_cov | output | OUT_W | Test coverage, scaled by 10000 |
| fault_cov | output | OUT_W | Fault coverage, scaled by 10000 |
| atpg_eff | output | OUT_W | ATPG effectiveness, scaled by 10000 |
| div_zero | output | 3 | Zero-denominator flags per ratio |
| cat_total | output | 5*SUM_W | Packed category totals |

## Verification
The assertions check the following on every cycle:
- counters hold at their ceiling and never fall except through clear;
- err_code follows out-of-range beats;
- clear empties the totals;
- busy rises on an accepted start;
- done is a single-cycle pulse;
- reported ratios never exceed 10000.

Only the bench's scenarios can show the rest:
- the class-to-category mapping;
- the exact quotient values and the zero-denominator cases;
- the latency of done;
- that beats and a second start arriving during a computation leave its result unchanged.

// File: rtl/fault_tally_pkg.sv
// Shared constants and the class-to-category mapping for the fault tally unit.
// Assumes class codes are dense from 0 and categories are numbered 0..4.
package fault_tally_pkg;
    localparam int NUM_CLASSES = 12;
    localparam int NUM_CATS    = 5;
    localparam int CODE_W      = 4;
    localparam int SCALE       = 10000;
    localparam int SCALE_W     = 14;

    typedef enum logic [2:0] {
        CAT_DET   = 3'd0,
        CAT_POSS  = 3'd1,
        CAT_UNDET = 3'd2,
        CAT_AUNT  = 3'd3,
        CAT_NDET  = 3'd4
    } cat_e;

    // Map a class index to the category it rolls up into.
    function automatic cat_e class_to_cat(input int idx);
        if (idx <= 2)      return CAT_DET;
        else if (idx <= 4) return CAT_POSS;
        else if (idx <= 8) return CAT_UNDET;
        else if (idx == 9) return CAT_AUNT;
        else               return CAT_NDET;
    endfunction
endpackage

// File: rtl/fault_class_counters.sv
// One saturating counter per fault class, plus an out-of-range code flag.
// Assumes in_code is only meaningful while in_valid is high; clr wins over a beat.
module fault_class_counters
    import fault_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              in_valid,
    input  logic [CODE_W-1:0]                 in_code,
    output logic [NUM_CLASSES-1:0][CNT_W-1:0] cnt,
    output logic                              err_code
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic code_bad;
    assign code_bad = in_valid && (in_code >= CODE_W'(NUM_CLASSES));

    // Flag an out-of-range code one cycle after it is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) err_code <= 1'b0;
        else        err_code <= code_bad;
    end

    // R3
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_bad |=> err_code);

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_cls
        logic hit;
        assign hit = in_valid && (in_code == CODE_W'(g));

        // Count beats of this class, holding at the ceiling.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)               cnt[g] <= '0;
            else if (hit && cnt[g] != CNT_MAX) cnt[g] <= cnt[g] + 1'b1;
        end

        // R4
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == CNT_MAX && !clr) |=> cnt[g] == CNT_MAX);
        // R4
        cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> cnt[g] >= $past(cnt[g]));
    end
endmodule

// File: rtl/ratio_divider.sv
// Restoring divider producing one quotient bit per clock.
// Captures operands on an accepted start; the result holds until the next start.
// A zero denominator forces the quotient to 0 and raises dz.
module ratio_divider #(
    parameter int NUM_W = 34,
    parameter int DEN_W = 20,
    parameter int OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] quot,
    output logic             dz
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  dvd, q;
    logic [DEN_W:0]    rem, rem_sh, rem_nx;
    logic [DEN_W-1:0]  den_r;
    logic [STEP_W-1:0] steps;
    logic              ge;
    logic [NUM_W-1:0]  q_nx;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        rem_sh = {rem[DEN_W-1:0], dvd[NUM_W-1]};
        ge     = rem_sh >= {1'b0, den_r};
        rem_nx = ge ? rem_sh - {1'b0, den_r} : rem_sh;
        q_nx   = {q[NUM_W-2:0], ge};
    end

    // Sequence the division and publish the result with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd <= '0; q <= '0; rem <= '0; den_r <= '0; steps <= '0;
            busy <= 1'b0; done <= 1'b0; quot <= '0; dz <= 1'b0;
        end else if (start && !busy) begin
            dvd <= num; q <= '0; rem <= '0; den_r <= den;
            steps <= STEP_W'(NUM_W); busy <= 1'b1; done <= 1'b0;
            dz <= (den == '0);
        end else if (busy) begin
            dvd   <= dvd << 1;
            q     <= q_nx;
            rem   <= rem_nx;
            steps <= steps - 1'b1;
            if (steps == STEP_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
                quot <= dz ? '0 : q_nx[OUT_W-1:0];
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/fault_tally_cov.sv
// Fault class tally with coverage ratios.
// Class counters feed a category roll-up. Three parallel dividers compute
// test coverage, fault coverage and ATPG effectiveness scaled by 10000.
// Assumes OUT_W is wide enough to hold 10000.
module fault_tally_cov
    import fault_tally_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int OUT_W = 14,
    localparam int SUM_W = CNT_W + 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      in_valid,
    input  logic [CODE_W-1:0]         in_code,
    output logic                      err_code,
    input  logic                      calc_start,
    output logic                      busy,
    output logic                      done,
    output logic [OUT_W-1:0]          test_cov,
    output logic [OUT_W-1:0]          fault_cov,
    output logic [OUT_W-1:0]          atpg_eff,
    output logic [2:0]                div_zero,
    output logic [NUM_CATS*SUM_W-1:0] cat_total
);
    localparam int NUM_W = SUM_W + SCALE_W;

    logic [NUM_CLASSES-1:0][CNT_W-1:0] cnt;
    logic [NUM_CATS-1:0][SUM_W-1:0]    cat;
    logic [SUM_W-1:0]                  all_f, resolv;
    logic [2:0][NUM_W-1:0]             num;
    logic [2:0][SUM_W-1:0]             den;
    logic [2:0][OUT_W-1:0]             q;
    logic [2:0]                        busy_v, done_v;

    fault_class_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_code(in_code), .cnt(cnt), .err_code(err_code)
    );

    // Roll class counters up into categories and the grand total.
    always_comb begin
        cat = '0;
        for (int i = 0; i < NUM_CLASSES; i++)
            cat[class_to_cat(i)] = cat[class_to_cat(i)] + SUM_W'(cnt[i]);
        all_f = '0;
        for (int k = 0; k < NUM_CATS; k++)
            all_f = all_f + cat[k];
        resolv = cat[CAT_DET] + cat[CAT_POSS] + cat[CAT_UNDET];
    end

    // Select numerator and denominator for each quality metric.
    always_comb begin
        num[0] = NUM_W'(cat[CAT_DET]) * NUM_W'(SCALE);
        den[0] = all_f - cat[CAT_UNDET];
        num[1] = NUM_W'(cat[CAT_DET]) * NUM_W'(SCALE);
        den[1] = all_f;
        num[2] = NUM_W'(resolv) * NUM_W'(SCALE);
        den[2] = all_f;
    end

    for (genvar m = 0; m < 3; m++) begin : g_div
        ratio_divider #(.NUM_W(NUM_W), .DEN_W(SUM_W), .OUT_W(OUT_W)) u_div (
            .clk(clk), .rst_n(rst_n), .start(calc_start), .num(num[m]),
            .den(den[m]), .busy(busy_v[m]), .done(done_v[m]), .quot(q[m]),
            .dz(div_zero[m])
        );
    end

    for (genvar k = 0; k < NUM_CATS; k++) begin : g_out
        assign cat_total[k*SUM_W +: SUM_W] = cat[k];
    end

    assign busy      = |busy_v;
    assign done      = done_v[0];
    assign test_cov  = q[0];
    assign fault_cov = q[1];
    assign atpg_eff  = q[2];

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cat_total == '0);
    // R6
    test_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> test_cov <= OUT_W'(SCALE));
    // R7
    fault_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fault_cov <= OUT_W'(SCALE));
    // R8
    eff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> atpg_eff <= OUT_W'(SCALE));
endmodule

// File: tb/fault_tally_cov_bench.sv
module fault_tally_cov_bench;
    localparam int CNT_W = 4;
    localparam int OUT_W = 14;
    localparam int SUM_W = CNT_W + 4;
    localparam int NUM_W = SUM_W + 14;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_valid = 1'b0, calc_start = 1'b0;
    logic [3:0] in_code = '0;
    logic err_code, busy, done;
    logic [OUT_W-1:0] test_cov, fault_cov, atpg_eff;
    logic [2:0] div_zero;
    logic [5*SUM_W-1:0] cat_total;

    int checks = 0, errors = 0;
    int unsigned mdl[12];

    always #2 clk = ~clk;

    fault_tally_cov #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_fault_tally_cov (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_code(in_code),
        .err_code(err_code), .calc_start(calc_start), .busy(busy), .done(done),
        .test_cov(test_cov), .fault_cov(fault_cov), .atpg_eff(atpg_eff),
        .div_zero(div_zero), .cat_total(cat_total)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cat_of(input int c);
        if (c <= 2) return 0;
        if (c <= 4) return 1;
        if (c <= 8) return 2;
        if (c == 9) return 3;
        return 4;
    endfunction

    function automatic int unsigned msum(input int k);
        int unsigned s = 0;
        for (int i = 0; i < 12; i++) if (cat_of(i) == k) s += mdl[i];
        return s;
    endfunction

    function automatic int unsigned ratio(input int unsigned n, input int unsigned d);
        return (d == 0) ? 0 : (n * 10000) / d;
    endfunction

    task automatic mclear();
        for (int i = 0; i < 12; i++) mdl[i] = 0;
    endtask

    task automatic mbump(input int c);
        if (c < 12 && mdl[c] < CMAX) mdl[c]++;
    endtask

    // One beat; checks the error flag one edge later (R3).
    task automatic beat(input int c);
        in_valid = 1'b1; in_code = 4'(c);
        mbump(c);
        @(negedge clk);
        in_valid = 1'b0;
        chk(err_code == (c >= 12), "R3 err_code", err_code, c >= 12);
    endtask

    task automatic check_totals(input string tag);
        for (int k = 0; k < 5; k++)
            chk(cat_total[k*SUM_W +: SUM_W] == SUM_W'(msum(k)), tag,
                cat_total[k*SUM_W +: SUM_W], msum(k));
    endtask

    task automatic calc(input bit noise);
        int unsigned a, d0, u, e0, e1, e2;
        logic [2:0] edz;
        a = 0;
        for (int k = 0; k < 5; k++) a += msum(k);
        d0 = msum(0); u = msum(2);
        e0 = ratio(d0, a - u); e1 = ratio(d0, a);
        e2 = ratio(d0 + msum(1) + u, a);
        edz = {a == 0, a == 0, (a - u) == 0};
        calc_start = 1'b1;
        @(negedge clk);
        calc_start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        for (int k = 1; k <= NUM_W; k++) begin
            if (noise && (k == 3 || k == 5)) in_valid = 1'b1;
            if (noise && k == 4) calc_start = 1'b1;
            in_code = 4'd0;
            @(negedge clk);
            if (in_valid) mbump(0);
            in_valid = 1'b0; calc_start = 1'b0;
            if (k < NUM_W && done) chk(1'b0, "R10 early done", k, NUM_W);
        end
        chk(done == 1'b1, "R10 done latency", done, 1);
        chk(test_cov == OUT_W'(e0), "R6 test_cov", test_cov, e0);
        chk(fault_cov == OUT_W'(e1), "R7 fault_cov", fault_cov, e1);
        chk(atpg_eff == OUT_W'(e2), "R8 atpg_eff", atpg_eff, e2);
        chk(div_zero == edz, "R9 div_zero", div_zero, edz);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        if (noise) begin
            for (int k = 0; k < NUM_W + 6; k++) begin
                @(negedge clk);
                if (done) chk(1'b0, "R10 start during busy accepted", 1, 0);
            end
            chk(test_cov == OUT_W'(e0), "R10 result held", test_cov, e0);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        mclear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cat_total == '0, "R1 totals", cat_total, 0);
        chk(done == 0 && busy == 0 && err_code == 0, "R1 flags", {done, busy, err_code}, 0);
        chk(test_cov == 0 && fault_cov == 0 && atpg_eff == 0 && div_zero == 0,
            "R1 ratios", test_cov, 0);

        // R2 one beat of every valid class
        for (int c = 0; c < 12; c++) beat(c);
        check_totals("R2 mapping");
        calc(1'b0);   // expect 3750, 2500, 7500

        // R3 out-of-range codes leave the totals alone
        for (int c = 12; c < 16; c++) beat(c);
        check_totals("R3 no count");

        // R5 clear beats a simultaneous beat
        clr = 1'b1; in_valid = 1'b1; in_code = 4'd0;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0; mclear();
        check_totals("R5 clear priority");

        // R9 empty tally: every denominator zero
        calc(1'b0);
        // R9 undetectable only: test coverage denominator zero
        beat(5); beat(6);
        calc(1'b0);

        // R4 saturation
        clr = 1'b1; @(negedge clk); clr = 1'b0; mclear();
        for (int i = 0; i < 20; i++) beat(9);
        for (int i = 0; i < 20; i++) beat(0);
        check_totals("R4 saturation");
        calc(1'b0);

        // R10 beats and start during busy
        calc(1'b1);
        check_totals("R10 beats during busy counted");

        // random rounds
        for (int r = 0; r < 8; r++) begin
            clr = 1'b1; @(negedge clk); clr = 1'b0; mclear();
            for (int i = 0; i < int'($urandom_range(1, 40)); i++)
                beat(int'($urandom_range(0, 15)));
            check_totals("R2 random totals");
            calc(1'b0);
        end
        finish_run();
    end
endmodule